// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block keeps every row of an external dynamic memory alive and brings the memory up from power-on. After reset it waits a fixed settling time and then asks the access controller for a series of initialization cycles. Normal traffic is allowed only once those cycles have been granted. From then on a periodic timer adds one owed refresh per interval. Owed refreshes are offered to the access controller through a request/grant pair. If the count of postponed refreshes reaches its limit, the block raises an urgent flag so that the controller gives refresh priority over host traffic.

Two refresh styles are chosen by parameter. In row-address mode the block keeps its own row counter and presents the row to refresh. In the other mode the memory's internal counter is used: the controller performs CAS-before-RAS cycles and the row output stays at zero.

A sleep request moves the memory into its low-power self-refresh state, but only when no refresh is owed. While in this state the block drives the two strobes itself. CAS falls first, then RAS, and both are held low for at least the minimum entry time before the state is acknowledged. When sleep is released, both strobes rise together. The acknowledge is withdrawn only after the precharge time has passed, and then normal operation resumes with a fresh interval timer.

Top module: `dram_refresh_sched`

## Requirements
- R1: From reset, for exactly INIT_WAIT clock edges after reset is released, `ref_req` and `ready` stay low, `sr_own` and `sleep_ack` stay low, and both strobes stay high. On the INIT_WAIT-th edge, `ref_req` rises.
- R2: During initialization, `ref_req` stays high and `ready` stays low until INIT_CYC grants have been accepted. On the edge of the last grant, `ready` rises and `ref_req` falls.
- R3: In normal operation, with nothing owed, `ref_req` rises exactly REF_INT edges after normal operation begins or resumes. Later refreshes are owed every REF_INT edges.
- R4: Each accepted grant (`ref_gnt` high while `ref_req` is high) retires one owed refresh. `ref_req` falls on the edge that retires the last one.
- R5: `ref_urgent` is high exactly when MAX_OWED refreshes are owed. Further intervals with no grant do not raise the count above MAX_OWED.
- R6: In row-address mode (RAS_ONLY=1), `ref_row` advances by one on each accepted grant and wraps from its all-ones value to 0.
- R7: `sleep_req` has no effect while any refresh is owed. Self-refresh begins on the edge after the owed count has reached zero.
- R8: Self-refresh entry holds `sr_cas_n` low with `sr_ras_n` high for CSR_CYC edges. After that, `sr_ras_n` also falls.
- R9: Both strobes stay low for SR_MIN edges before `sleep_ack` rises. They then stay low for as long as `sleep_req` stays high.
- R10: On the edge after `sleep_req` falls, both strobes rise. `sleep_ack` remains high for PRE_CYC edges and then falls, on the same edge where `ready` rises.
- R11: While `sr_own` is high, `ref_req` and `ready` are low, and `ref_gnt` has no effect on `ref_row`.
- R12: `ref_gnt` while `ref_req` is low changes neither `ref_row` nor the owed count.
- R13: With RAS_ONLY=0, `ref_cbr` is 1 and `ref_row` stays 0. With RAS_ONLY=1, `ref_cbr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Access controller has performed the requested refresh cycle |
| sleep_req | input | 1 | Request to enter (high) or leave (low) self-refresh |
| ref_req | output | 1 | A refresh or initialization cycle is wanted |
| ref_urgent | output | 1 | Postponed-refresh limit reached; refresh takes priority |
| ref_row | output | ROW_BITS | Row to refresh in row-address mode |
| ref_cbr | output | 1 | Refresh cycles must use CAS-before-RAS |
| ready | output | 1 | Normal access allowed |
| sleep_ack | output | 1 | Self-refresh active (held through exit precharge) |
| sr_own | output | 1 | Block drives the strobes itself |
| sr_ras_n | output | 1 | RAS strobe while `sr_own` is high |
| sr_cas_n | output | 1 | CAS strobe (both bytes) while `sr_own` is high |

## Verification
The bench runs a reduced configuration with 8 rows and short timers. It measures each phase length by counting edges and compares it with the parameter. An off-by-one counter would therefore show up as a wrong settling, entry, hold, precharge or interval length.

It lets owed refreshes pile up past the limit and then grants exactly MAX_OWED times. A count that does not saturate would leave `ref_req` high after those grants.

It raises sleep while a refresh is owed, so a block that sleeps with a debt would take the strobes too early. It checks that the row counter wraps on the eighth init grant, and that stray grants, with no request pending or during self-refresh, leave the row unchanged.

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int INIT_WAIT = 25000,
  parameter int INIT_CYC  = 8,
  parameter int REF_INT   = 1950,
  parameter int MAX_OWED  = 8,
  parameter int CSR_CYC   = 1,
  parameter int SR_MIN    = 12501,
  parameter int PRE_CYC   = 10,
  parameter int ROW_BITS  = 10,
  parameter bit RAS_ONLY  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_gnt,
  input  logic                sleep_req,
  output logic                ref_req,
  output logic                ref_urgent,
  output logic [ROW_BITS-1:0] ref_row,
  output logic                ref_cbr,
  output logic                ready,
  output logic                sleep_ack,
  output logic                sr_own,
  output logic                sr_ras_n,
  output logic                sr_cas_n
);
  localparam int CW = $clog2(INIT_WAIT + INIT_CYC + REF_INT + CSR_CYC + SR_MIN + PRE_CYC + 1);
  localparam int OW = $clog2(MAX_OWED + 1);

  typedef enum logic [2:0] {
    S_WAIT, S_INIT, S_RUN, S_SR_CAS, S_SR_ENTER, S_SELF, S_SR_EXIT
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [OW-1:0] owed;
  logic          gnt;
  logic          tick;

  assign gnt  = ref_gnt && ref_req;
  assign tick = (st == S_RUN) && (cnt == CW'(REF_INT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      cnt  <= '0;
      owed <= '0;
    end else begin
      case (st)
        S_WAIT:
          if (cnt == CW'(INIT_WAIT - 1)) begin st <= S_INIT; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_INIT:
          if (gnt) begin
            if (cnt == CW'(INIT_CYC - 1)) begin st <= S_RUN; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
        S_RUN:
          if (sleep_req && owed == '0) begin
            st  <= S_SR_CAS;
            cnt <= '0;
          end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick && !gnt && owed != OW'(MAX_OWED)) owed <= owed + 1'b1;
            else if (!tick && gnt) owed <= owed - 1'b1;
          end
        S_SR_CAS:
          if (cnt == CW'(CSR_CYC - 1)) begin st <= S_SR_ENTER; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_SR_ENTER:
          if (cnt == CW'(SR_MIN - 1)) begin st <= S_SELF; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        S_SELF:
          if (!sleep_req) begin st <= S_SR_EXIT; cnt <= '0; end
        S_SR_EXIT:
          if (cnt == CW'(PRE_CYC - 1)) begin st <= S_RUN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        default: st <= S_WAIT;
      endcase
    end
  end

  generate
    if (RAS_ONLY) begin : g_row
      logic [ROW_BITS-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) row_q <= '0;
        else if (gnt) row_q <= row_q + 1'b1;
      end
      assign ref_row = row_q;
    end else begin : g_cbr
      assign ref_row = '0;
    end
  endgenerate

  assign ref_cbr    = !RAS_ONLY;
  assign ref_req    = (st == S_INIT) || (st == S_RUN && owed != '0);
  assign ref_urgent = (st == S_RUN) && (owed == OW'(MAX_OWED));
  assign ready      = (st == S_RUN);
  assign sr_own     = st inside {S_SR_CAS, S_SR_ENTER, S_SELF, S_SR_EXIT};
  assign sr_cas_n   = !(st inside {S_SR_CAS, S_SR_ENTER, S_SELF});
  assign sr_ras_n   = !(st inside {S_SR_ENTER, S_SELF});
  assign sleep_ack  = st inside {S_SELF, S_SR_EXIT};
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int ROW_BITS = 10,
  parameter bit RAS_ONLY = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ref_gnt,
  input logic                sleep_req,
  input logic                ref_req,
  input logic                ref_urgent,
  input logic [ROW_BITS-1:0] ref_row,
  input logic                ref_cbr,
  input logic                ready,
  input logic                sleep_ack,
  input logic                sr_own,
  input logic                sr_ras_n,
  input logic                sr_cas_n
);
  a_r5_urgent_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req);

  a_r11_quiet_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    sr_own |-> (!ref_req && !ready));

  a_r8_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_ras_n) |-> (!sr_cas_n && $past(!sr_cas_n)));

  a_r9_ack_with_strobes_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_ack) |-> (!sr_ras_n && !sr_cas_n));

  a_r10_ras_up_before_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_ack) |-> (sr_ras_n && $past(sr_ras_n) && ready));

  a_r7_no_sleep_while_owed: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ref_req) |=> !sr_own);

  generate
    if (RAS_ONLY) begin : g_row_chk
      a_r6_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> ref_row == ROW_BITS'($past(ref_row) + 1'b1));
      a_r12_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_req && ref_gnt) |=> $stable(ref_row));
    end else begin : g_cbr_chk
      a_r13_cbr_row_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_row == '0) && ref_cbr);
    end
  endgenerate
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .ROW_BITS(ROW_BITS), .RAS_ONLY(RAS_ONLY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sleep_req(sleep_req),
  .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_row(ref_row),
  .ref_cbr(ref_cbr), .ready(ready), .sleep_ack(sleep_ack), .sr_own(sr_own),
  .sr_ras_n(sr_ras_n), .sr_cas_n(sr_cas_n)
);

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int P_WAIT = 20;
  localparam int P_INIT = 8;
  localparam int P_INT  = 16;
  localparam int P_OWE  = 4;
  localparam int P_CSR  = 2;
  localparam int P_SRM  = 25;
  localparam int P_PRE  = 3;
  localparam int P_RB   = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ref_gnt, sleep_req;
  logic ref_req, ref_urgent, ref_cbr, ready, sleep_ack, sr_own, sr_ras_n, sr_cas_n;
  logic [P_RB-1:0] ref_row;
  logic c_req, c_urg, c_cbr, c_ready, c_ack, c_own, c_ras_n, c_cas_n;
  logic [P_RB-1:0] c_row;

  dram_refresh_sched #(.INIT_WAIT(P_WAIT), .INIT_CYC(P_INIT), .REF_INT(P_INT),
    .MAX_OWED(P_OWE), .CSR_CYC(P_CSR), .SR_MIN(P_SRM), .PRE_CYC(P_PRE),
    .ROW_BITS(P_RB), .RAS_ONLY(1'b1)) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sleep_req(sleep_req),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_row(ref_row), .ref_cbr(ref_cbr),
    .ready(ready), .sleep_ack(sleep_ack), .sr_own(sr_own),
    .sr_ras_n(sr_ras_n), .sr_cas_n(sr_cas_n));

  dram_refresh_sched #(.INIT_WAIT(P_WAIT), .INIT_CYC(P_INIT), .REF_INT(P_INT),
    .MAX_OWED(P_OWE), .CSR_CYC(P_CSR), .SR_MIN(P_SRM), .PRE_CYC(P_PRE),
    .ROW_BITS(P_RB), .RAS_ONLY(1'b0)) i_cbr (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sleep_req(sleep_req),
    .ref_req(c_req), .ref_urgent(c_urg), .ref_row(c_row), .ref_cbr(c_cbr),
    .ready(c_ready), .sleep_ack(c_ack), .sr_own(c_own),
    .sr_ras_n(c_ras_n), .sr_cas_n(c_cas_n));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk("watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    rst_n = 1'b0; ref_gnt = 1'b0; sleep_req = 1'b0;
    repeat (3) step;
    chk("R1 req in reset", ref_req, 0);
    chk("R1 ready in reset", ready, 0);
    chk("R1 own in reset", sr_own, 0);
    chk("R1 ras_n in reset", sr_ras_n, 1);
    chk("R1 cas_n in reset", sr_cas_n, 1);
    chk("R1 ack in reset", sleep_ack, 0);
    chk("R13 cbr flag main", ref_cbr, 0);
    chk("R13 cbr flag alt", c_cbr, 1);

    rst_n = 1'b1;
    n = 0; bad = 0;
    while (!ref_req && n < 1000) begin
      step; n++;
      if (ready || sr_own || !sr_ras_n) bad++;
    end
    chk("R1 settle length", n, P_WAIT);
    chk("R1 quiet while settling", bad, 0);

    for (int i = 0; i < P_INIT; i++) begin
      ref_gnt = 1'b1; step; ref_gnt = 1'b0;
      chk("R6 row after init grant", ref_row, (i + 1) % (1 << P_RB));
      chk("R13 alt row", c_row, 0);
      if (i < P_INIT - 1) begin
        chk("R2 ready held low", ready, 0);
        chk("R2 req held", ref_req, 1);
      end else begin
        chk("R2 ready after last grant", ready, 1);
        chk("R2 req dropped", ref_req, 0);
      end
    end

    ref_gnt = 1'b1; step; ref_gnt = 1'b0;
    n = 1;
    chk("R12 stray grant row", ref_row, 0);
    chk("R12 stray grant req", ref_req, 0);
    while (!ref_req && n < 1000) begin step; n++; end
    chk("R3 first interval", n, P_INT);

    n = 0;
    while (!ref_urgent && n < 1000) begin step; n++; end
    chk("R5 urgent after limit", n, (P_OWE - 1) * P_INT);
    repeat (2 * P_INT) step;
    chk("R5 urgent held", ref_urgent, 1);
    for (int i = 0; i < P_OWE; i++) begin
      ref_gnt = 1'b1; step;
      chk("R4 req after grant", ref_req, (i < P_OWE - 1) ? 1 : 0);
      chk("R5 urgent cleared", ref_urgent, 0);
    end
    ref_gnt = 1'b0;
    chk("R6 row after run grants", ref_row, (P_INIT + P_OWE) % (1 << P_RB));

    n = 0;
    while (!ref_req && n < 1000) begin step; n++; end
    chk("R3 interval spacing", n, P_INT - P_OWE);

    sleep_req = 1'b1;
    repeat (3) step;
    chk("R7 sleep ignored while owed", sr_own, 0);
    chk("R7 req kept", ref_req, 1);
    ref_gnt = 1'b1; step; ref_gnt = 1'b0;
    chk("R7 awake on retiring edge", sr_own, 0);
    step;
    chk("R8 cas falls first", sr_cas_n, 0);
    chk("R8 ras still high", sr_ras_n, 1);
    chk("R11 no req in sleep", ref_req, 0);
    chk("R11 not ready in sleep", ready, 0);
    n = 0;
    while (sr_own && sr_ras_n && n < 100) begin n++; step; end
    chk("R8 cas lead length", n, P_CSR);
    chk("R8 cas low with ras", sr_cas_n, 0);

    n = 0; bad = 0;
    while (!sleep_ack && n < 1000) begin
      if (sr_ras_n || sr_cas_n) bad++;
      n++; step;
    end
    chk("R9 entry hold length", n, P_SRM);
    chk("R9 strobes low in entry", bad, 0);

    ref_gnt = 1'b1;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      step;
      if (sr_ras_n || sr_cas_n || !sleep_ack || ref_req) bad++;
    end
    ref_gnt = 1'b0;
    chk("R9 held in self-refresh", bad, 0);
    chk("R11 grant ignored in sleep", ref_row, (P_INIT + P_OWE + 1) % (1 << P_RB));

    sleep_req = 1'b0; step;
    chk("R10 ras up", sr_ras_n, 1);
    chk("R10 cas up", sr_cas_n, 1);
    chk("R10 ack held", sleep_ack, 1);
    chk("R10 not ready yet", ready, 0);
    n = 0;
    while (sleep_ack && n < 100) begin n++; step; end
    chk("R10 precharge length", n, P_PRE);
    chk("R10 ready after wake", ready, 1);
    chk("R10 strobes released", sr_own, 0);

    n = 0;
    while (!ref_req && n < 1000) begin step; n++; end
    chk("R3 timer restarted", n, P_INT);
    chk("R13 alt row stays zero", c_row, 0);
    chk("R13 alt tracks req", c_req, ref_req);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule